// File: doc/BRIEF.md
# Sector Protection Gate

This block guards a sector-organised non-volatile array against unwanted program and erase operations. It keeps one protection bit per sector. Each program or erase request is checked against those bits, and the block issues either a grant, naming the sectors that may be touched, or a reject. The array, the high-voltage circuits and the erase timing all live outside the block. The block only decides which requests may proceed.

Commands arrive as writes on a small address/data port. A command cycle counts only if it follows a two-write key sequence. This keeps stray bus writes from starting an operation. Four commands are supported:

- erase one sector
- erase any group of sectors, given as a mask
- program one sector
- add protection to any group of sectors

A temporary-unprotect input lets protected sectors be changed in-system. It does not alter the stored bits, so protection returns as soon as the input drops. A query port reports the stored protection bit of any sector. When a group erase touches protected sectors, the protected ones are skipped and recorded in sticky flags.

Top module: `sector_guard`

## Requirements
- R1: A command cycle is taken only as the third write of the sequence: address 0x555 with data 0xAA, then address 0x2AA with data 0x55, then the command. Cycles without `wr_en` may fall between these writes. A write that does not match the expected key returns the sequencer to idle, and the following write is examined as a possible first key. A command write made from idle has no effect.
- R2: Command data 0xA0 programs the sector whose index is in `wr_addr[2:0]`, and 0x30 erases it. If that sector is not protected, `gnt` is high for exactly one cycle, starting one clock after the command write. In that cycle `gnt_mask` is the one-hot mask of the sector, and `gnt_erase` is 1 for an erase and 0 for a program.
- R3: A program or single-sector erase aimed at a protected sector gives a one-cycle `rej` pulse and no `gnt`.
- R4: Command data 0x60 sets protection for every sector whose bit is 1 in `wr_addr[7:0]`. Bits that are already set stay set, and no grant or reject is issued.
- R5: After reset, all sectors are unprotected, `skip_flags` is zero, and `gnt` and `rej` are low.
- R6: `query_prot` shows the stored protection bit of the sector selected by `query_sect`, with no clock delay.
- R7: While `tmp_unprot` is high, protected sectors are granted for program and erase, and `query_prot` still shows them as protected. Once `tmp_unprot` is low, the same sectors are rejected again.
- R8: Command data 0x50 is a group erase over the mask in `wr_addr[7:0]`. It grants, with `gnt_erase` = 1, exactly the sectors in the mask that are not currently protected.
- R9: The protected sectors that a group erase skips are ORed into the sticky `skip_flags`, which only reset clears. A group erase with an empty mask, or one in which every sector is protected, gives `rej`.
- R10: A command cycle carrying any other data value produces neither `gnt` nor `rej` and leaves the protection bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the command port |
| wr_addr | input | 12 | Write address; carries the sector index or mask in command cycles |
| wr_data | input | 8 | Write data; carries the key values or the command code |
| tmp_unprot | input | 1 | Temporary suspension of protection |
| query_sect | input | 3 | Sector whose protection bit is reported |
| query_prot | output | 1 | Stored protection bit of `query_sect` |
| gnt | output | 1 | One-cycle grant pulse |
| gnt_erase | output | 1 | Grant is for an erase (1) or a program (0) |
| gnt_mask | output | 8 | Sectors the grant covers |
| rej | output | 1 | One-cycle reject pulse |
| skip_flags | output | 8 | Sticky record of sectors skipped by group erases |

## Verification
Single-sector program and erase are tried on both unprotected and protected sectors. This tells the protection test apart from the command decode and the kind bit. Key sequences are sent with a wrong first key, with a wrong second key, and with idle gaps between writes. These show that only the exact ordered pair arms the command cycle. Group erases are sent with a mixed mask, an all-protected mask, an empty mask and the full mask under the temporary override. These separate partial granting, the sticky skip record and the reject path. Queries made under the override, and requests repeated after it is released, show that the override masks protection without changing the stored bits.

// File: rtl/sg_pkg.sv
package sg_pkg;
   localparam logic [11:0] KEY1_ADDR = 12'h555;
   localparam logic [7:0]  KEY1_DATA = 8'hAA;
   localparam logic [11:0] KEY2_ADDR = 12'h2AA;
   localparam logic [7:0]  KEY2_DATA = 8'h55;
   localparam logic [7:0]  OPC_PROG   = 8'hA0;
   localparam logic [7:0]  OPC_ERASE1 = 8'h30;
   localparam logic [7:0]  OPC_ERASEG = 8'h50;
   localparam logic [7:0]  OPC_PROT   = 8'h60;

   typedef enum logic [1:0] {SEQ_IDLE, SEQ_KEY1, SEQ_KEY2} seq_t;
   typedef enum logic [2:0] {OP_NONE, OP_PROG, OP_ERASE1, OP_ERASEG, OP_PROT} op_t;
endpackage

// File: rtl/sg_unlock_seq.sv
module sg_unlock_seq
   import sg_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output op_t               cmd_op
);
   seq_t state, state_nx;
   logic key1_hit, key2_hit;

   assign key1_hit = (wr_addr == ADDR_W'(KEY1_ADDR)) && (wr_data == DATA_W'(KEY1_DATA));
   assign key2_hit = (wr_addr == ADDR_W'(KEY2_ADDR)) && (wr_data == DATA_W'(KEY2_DATA));

   always_comb begin
      state_nx = state;
      if (wr_en) begin
         case (state)
            SEQ_IDLE: state_nx = key1_hit ? SEQ_KEY1 : SEQ_IDLE;
            SEQ_KEY1: state_nx = key2_hit ? SEQ_KEY2 : SEQ_IDLE;
            default:  state_nx = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SEQ_IDLE;
      else        state <= state_nx;
   end

   always_comb begin
      cmd_op = OP_NONE;
      if (wr_en && state == SEQ_KEY2) begin
         if      (wr_data == DATA_W'(OPC_PROG))   cmd_op = OP_PROG;
         else if (wr_data == DATA_W'(OPC_ERASE1)) cmd_op = OP_ERASE1;
         else if (wr_data == DATA_W'(OPC_ERASEG)) cmd_op = OP_ERASEG;
         else if (wr_data == DATA_W'(OPC_PROT))   cmd_op = OP_PROT;
      end
   end

   // R1
   idle_stray_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_IDLE && wr_en && !key1_hit) |=> (state == SEQ_IDLE));
   // R1
   key2_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_KEY1 && wr_en && !key2_hit) |=> (state == SEQ_IDLE));
endmodule

// File: rtl/sg_prot_reg.sv
module sg_prot_reg #(
   parameter int N_SECT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [N_SECT-1:0] set_mask,
   input  logic              tmp_unprot,
   output logic [N_SECT-1:0] prot_q,
   output logic [N_SECT-1:0] eff_prot
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prot_q <= '0;
      else if (set_en) prot_q <= prot_q | set_mask;
   end

   for (genvar i = 0; i < N_SECT; i++) begin : g_eff
      assign eff_prot[i] = prot_q[i] & ~tmp_unprot;
   end

   // R4
   prot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_q & $past(prot_q)) == $past(prot_q));
endmodule

// File: rtl/sg_decide.sv
module sg_decide
   import sg_pkg::*;
#(
   parameter int N_SECT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  op_t               cmd_op,
   input  logic [N_SECT-1:0] cmd_mask,
   input  logic [N_SECT-1:0] eff_prot,
   output logic              prot_set,
   output logic              gnt_q,
   output logic              erase_q,
   output logic [N_SECT-1:0] mask_q,
   output logic              rej_q,
   output logic [N_SECT-1:0] skip_q
);
   localparam int IDX_W = $clog2(N_SECT);
   localparam logic [IDX_W:0] N_CNT = (IDX_W+1)'(N_SECT);

   logic [IDX_W-1:0]  idx;
   logic              idx_ok;
   logic [N_SECT-1:0] one_hot, allow, skipped;
   logic              gnt_c, erase_c, rej_c;
   logic [N_SECT-1:0] mask_c, skip_c;

   assign idx     = cmd_mask[IDX_W-1:0];
   assign idx_ok  = {1'b0, idx} < N_CNT;
   assign one_hot = N_SECT'(1) << idx;
   assign allow   = cmd_mask & ~eff_prot;
   assign skipped = cmd_mask & eff_prot;

   always_comb begin
      gnt_c = 1'b0; erase_c = 1'b0; rej_c = 1'b0;
      mask_c = '0; skip_c = '0; prot_set = 1'b0;
      case (cmd_op)
         OP_PROG, OP_ERASE1: begin
            if (idx_ok && (one_hot & eff_prot) == '0) begin
               gnt_c   = 1'b1;
               mask_c  = one_hot;
               erase_c = (cmd_op == OP_ERASE1);
            end else begin
               rej_c = 1'b1;
            end
         end
         OP_ERASEG: begin
            skip_c = skipped;
            if (allow != '0) begin
               gnt_c = 1'b1; erase_c = 1'b1; mask_c = allow;
            end else begin
               rej_c = 1'b1;
            end
         end
         OP_PROT: prot_set = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_q <= 1'b0; erase_q <= 1'b0; mask_q <= '0;
         rej_q <= 1'b0; skip_q  <= '0;
      end else begin
         gnt_q   <= gnt_c;
         erase_q <= erase_c;
         mask_q  <= mask_c;
         rej_q   <= rej_c;
         skip_q  <= skip_q | skip_c;
      end
   end

   // R2
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gnt_q && rej_q));
   // R2
   grant_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_q |-> (mask_q != '0));
   // R9
   skip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (skip_q & $past(skip_q)) == $past(skip_q));
endmodule

// File: rtl/sector_guard.sv
module sector_guard
   import sg_pkg::*;
#(
   parameter int N_SECT = 8,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [DATA_W-1:0]         wr_data,
   input  logic                      tmp_unprot,
   input  logic [$clog2(N_SECT)-1:0] query_sect,
   output logic                      query_prot,
   output logic                      gnt,
   output logic                      gnt_erase,
   output logic [N_SECT-1:0]         gnt_mask,
   output logic                      rej,
   output logic [N_SECT-1:0]         skip_flags
);
   if (N_SECT < 2 || N_SECT > ADDR_W) begin : g_bad_sect
      $error("sector_guard: N_SECT must lie in 2..ADDR_W");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("sector_guard: ADDR_W must be at least 12");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("sector_guard: DATA_W must be at least 8");
   end

   op_t               cmd_op;
   logic              prot_set;
   logic [N_SECT-1:0] prot_q, eff_prot;

   sg_unlock_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .cmd_op(cmd_op));

   sg_prot_reg #(.N_SECT(N_SECT)) u_prot (
      .clk(clk), .rst_n(rst_n), .set_en(prot_set),
      .set_mask(wr_addr[N_SECT-1:0]), .tmp_unprot(tmp_unprot),
      .prot_q(prot_q), .eff_prot(eff_prot));

   sg_decide #(.N_SECT(N_SECT)) u_dec (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op),
      .cmd_mask(wr_addr[N_SECT-1:0]), .eff_prot(eff_prot),
      .prot_set(prot_set), .gnt_q(gnt), .erase_q(gnt_erase),
      .mask_q(gnt_mask), .rej_q(rej), .skip_q(skip_flags));

   assign query_prot = prot_q[query_sect];

   // R3
   prot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt |-> ((gnt_mask & $past(eff_prot)) == '0));
   // R10
   prot_only_by_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_q != $past(prot_q)) |-> ($past(cmd_op) == OP_PROT));
endmodule

// File: tb/sector_guard_tb.sv
module sector_guard_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        tmp_unprot = 1'b0;
   logic [2:0]  query_sect = '0;
   logic        query_prot, gnt, gnt_erase, rej;
   logic [7:0]  gnt_mask, skip_flags;
   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   sector_guard u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tmp_unprot(tmp_unprot), .query_sect(query_sect),
      .query_prot(query_prot), .gnt(gnt), .gnt_erase(gnt_erase),
      .gnt_mask(gnt_mask), .rej(rej), .skip_flags(skip_flags));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cmd(input logic [11:0] a, input logic [7:0] d);
      wr(12'h555, 8'hAA);
      wr(12'h2AA, 8'h55);
      wr(a, d);
   endtask

   task automatic expect_out(input string tag, input logic g, input logic e,
                             input logic [7:0] m, input logic r);
      check({tag, " gnt"}, gnt, g);
      if (g) begin
         check({tag, " gnt_erase"}, gnt_erase, e);
         check({tag, " gnt_mask"}, gnt_mask, m);
      end
      check({tag, " rej"}, rej, r);
   endtask

   task automatic query_all(input string tag, input logic [7:0] exp);
      for (int i = 0; i < 8; i++) begin
         query_sect = 3'(i);
         #1;
         check(tag, query_prot, exp[i]);
      end
   endtask

   task automatic t_reset;
      check("R5 gnt", gnt, 1'b0);
      check("R5 rej", rej, 1'b0);
      check("R5 skip_flags", skip_flags, 8'h00);
      query_all("R5 R6 prot after reset", 8'h00);
   endtask

   task automatic t_single;
      cmd(12'h003, 8'hA0);
      expect_out("R2 program s3", 1'b1, 1'b0, 8'h08, 1'b0);
      @(negedge clk);
      check("R2 pulse width", gnt, 1'b0);
      cmd(12'h005, 8'h30);
      expect_out("R2 erase s5", 1'b1, 1'b1, 8'h20, 1'b0);
   endtask

   task automatic t_unlock;
      wr(12'h555, 8'hAB);
      wr(12'h2AA, 8'h55);
      wr(12'h002, 8'hA0);
      expect_out("R1 bad first key", 1'b0, 1'b0, 8'h00, 1'b0);
      wr(12'h555, 8'hAA);
      wr(12'h2AA, 8'h54);
      wr(12'h002, 8'hA0);
      expect_out("R1 bad second key", 1'b0, 1'b0, 8'h00, 1'b0);
      wr(12'h555, 8'hAA);
      repeat (3) @(negedge clk);
      wr(12'h2AA, 8'h55);
      repeat (2) @(negedge clk);
      wr(12'h002, 8'hA0);
      expect_out("R1 gaps allowed", 1'b1, 1'b0, 8'h04, 1'b0);
      wr(12'h002, 8'hA0);
      expect_out("R1 command from idle", 1'b0, 1'b0, 8'h00, 1'b0);
   endtask

   task automatic t_protect;
      cmd(12'h012, 8'h60);
      expect_out("R4 protect no pulse", 1'b0, 1'b0, 8'h00, 1'b0);
      query_all("R4 R6 prot 1,4", 8'h12);
      cmd(12'h004, 8'hA0);
      expect_out("R3 program protected s4", 1'b0, 1'b0, 8'h00, 1'b1);
      cmd(12'h001, 8'h30);
      expect_out("R3 erase protected s1", 1'b0, 1'b0, 8'h00, 1'b1);
      cmd(12'h080, 8'h60);
      query_all("R4 protect accumulates", 8'h92);
   endtask

   task automatic t_group;
      cmd(12'h01E, 8'h50);
      expect_out("R8 mixed group", 1'b1, 1'b1, 8'h0C, 1'b0);
      check("R9 skip after mixed", skip_flags, 8'h12);
      cmd(12'h090, 8'h50);
      expect_out("R9 all-protected group", 1'b0, 1'b0, 8'h00, 1'b1);
      check("R9 skip accumulates", skip_flags, 8'h92);
      cmd(12'h000, 8'h50);
      expect_out("R9 empty group", 1'b0, 1'b0, 8'h00, 1'b1);
      check("R9 skip held", skip_flags, 8'h92);
   endtask

   task automatic t_temp;
      @(negedge clk);
      tmp_unprot = 1'b1;
      cmd(12'h004, 8'hA0);
      expect_out("R7 override program s4", 1'b1, 1'b0, 8'h10, 1'b0);
      cmd(12'h0FF, 8'h50);
      expect_out("R7 override full group", 1'b1, 1'b1, 8'hFF, 1'b0);
      check("R7 skip unchanged", skip_flags, 8'h92);
      query_all("R7 stored bits kept", 8'h92);
      @(negedge clk);
      tmp_unprot = 1'b0;
      cmd(12'h004, 8'hA0);
      expect_out("R7 protection restored", 1'b0, 1'b0, 8'h00, 1'b1);
   endtask

   task automatic t_unknown;
      cmd(12'h001, 8'h77);
      expect_out("R10 unknown opcode", 1'b0, 1'b0, 8'h00, 1'b0);
      query_all("R10 prot unchanged", 8'h92);
      cmd(12'h000, 8'h30);
      expect_out("R10 s0 still open", 1'b1, 1'b1, 8'h01, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_unlock();
      t_protect();
      t_group();
      t_temp();
      t_unknown();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule